// File: doc/BRIEF.md
# Branch/Data Trace Message Encoder

This block sits beside a processor core and turns its retirement and data-access activity into compact trace messages. These are held in a small on-chip queue until an off-chip trace port drains them. Instructions that follow on sequentially leave no record. Only an instruction that changes program flow produces a message, and that message carries the instruction class and the full destination address. A data access that passes the address qualifiers produces an address message and then a data message. A watchpoint hit produces a one-entry marker.

Every message is stamped with a free-running cycle counter as it enters the queue. The stamp is the emission time, not the execution time. When the queue cannot take a message, the message is dropped. In its place an overflow marker goes into a reserved slot. Normal messages are then suppressed until a resynchronisation message carrying the full program counter has been queued. In stall mode the block instead raises a hold request to the core before the queue runs out of room, so no message is lost.

Top module: `trc_msg_encoder`

## Requirements
- R1: A retirement with `retire_valid=1`, `retire_nonseq=1` and flow tracing enabled queues one message with kind 4'b0001, info equal to `retire_itype`, and payload equal to `retire_pc`.
- R2: A retirement with `retire_nonseq=0` queues nothing.
- R3: Each message's stamp is the value of a 16-bit cycle counter in the cycle the message is written. The counter is 0 in the first cycle after reset and increments by one every cycle. Messages written in the same cycle share a stamp.
- R4: A qualified data access queues two messages in the same cycle: first kind 4'b0010 with the address as payload, then kind 4'b0011 with the data as payload, both with info 0.
- R5: A data access is qualified when `record_all=1`, or when for at least one of the four ranges k, `rng_en[k]=1` and lo_k <= address <= hi_k (inclusive). Bound k sits in bits [32k+31:32k] of `rng_lo`/`rng_hi`. Otherwise the access queues nothing.
- R6: A data access with `dacc_core=1` never queues a message, even with `record_all=1`.
- R7: Normal messages may fill at most DEPTH-2 = 14 entries. An event whose messages would exceed that is dropped as a whole. In the same cycle a single overflow message (kind 4'b0100, info 0, payload 0) is queued.
- R8: After an overflow, every event is dropped until the first cycle whose starting occupancy is at most SYNC_LVL = 8. In that cycle a sync message is queued (kind 4'b0101, info 0, payload = `retire_pc` if `retire_valid=1` that cycle, else the last retired PC, which is 0 after reset). The event of that cycle is dropped, and normal operation resumes in the next cycle.
- R9: `stall_req` is 1 exactly when `stall_en=1` and the queue occupancy is at least DEPTH-3 = 13. A core that holds its events while `stall_req=1` never causes an overflow message.
- R10: Flow tracing is enabled at reset. A `trace_off` pulse disables it and a `trace_on` pulse enables it, with `trace_off` winning if both are high. The change takes effect from the next cycle and gates only branch messages.
- R11: Only one event is taken per cycle, with priority data access > branch > watchpoint. A watchpoint (`wp_hit=1`) queues kind 4'b0110 with info `wp_id` and payload 0.
- R12: Reset empties the queue, so `out_valid=0` and `stall_req=0`.
- R13: `out_valid` is 1 while the queue holds entries. Messages leave in the order they were written. The head is removed in a cycle with `out_valid=1` and `out_ready=1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_nonseq | input | 1 | The retiring instruction changes program flow |
| retire_itype | input | 4 | Class of the retiring flow-change instruction |
| retire_pc | input | 32 | Destination PC of the retiring instruction |
| dacc_valid | input | 1 | A data access happens this cycle |
| dacc_core | input | 1 | The access targets a core register |
| dacc_addr | input | 32 | Data access address |
| dacc_data | input | 32 | Data access value |
| wp_hit | input | 1 | Watchpoint hit this cycle |
| wp_id | input | 4 | Identifier of the watchpoint hit |
| trace_on | input | 1 | Pulse enabling flow tracing |
| trace_off | input | 1 | Pulse disabling flow tracing |
| record_all | input | 1 | Trace every non-core data access |
| rng_en | input | 4 | Enable per address qualifier |
| rng_lo | input | 128 | Lower bounds, 32 bits per qualifier |
| rng_hi | input | 128 | Upper bounds, 32 bits per qualifier |
| stall_en | input | 1 | Hold-the-core mode instead of dropping |
| stall_req | output | 1 | Request to hold the core |
| out_ready | input | 1 | Trace port takes the head message |
| out_valid | output | 1 | Queue is not empty |
| out_kind | output | 4 | Head message kind |
| out_info | output | 4 | Head message info field |
| out_payload | output | 32 | Head message payload |
| out_stamp | output | 16 | Head message stamp |

## Verification
An event presented before a clock edge is written into the queue at that edge. Its messages are therefore at the head of an otherwise empty queue one cycle later. `stall_req` and `out_valid` follow the occupancy in the cycle after each write or pop. The bench drives inputs on the falling edge and compares outputs on the following falling edge against a queue model that advances once per cycle. Its model decides drops, overflow and sync from the occupancy at the start of the cycle, as the requirements state. It also keeps its own stamp counter, started at the first cycle after reset.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int PC_W   = 32;
  localparam int TS_W   = 16;
  localparam int INFO_W = 4;

  typedef enum logic [3:0] {
    K_NONE   = 4'h0,
    K_BRANCH = 4'h1,
    K_DADDR  = 4'h2,
    K_DVAL   = 4'h3,
    K_OVF    = 4'h4,
    K_SYNC   = 4'h5,
    K_WATCH  = 4'h6
  } kind_e;

  typedef struct packed {
    kind_e              kind;
    logic [INFO_W-1:0]  info;
    logic [PC_W-1:0]    payload;
  } body_t;

  typedef struct packed {
    body_t              body;
    logic [TS_W-1:0]    stamp;
  } msg_t;
endpackage

// File: rtl/trc_range_match.sv
module trc_range_match #(
  parameter int AW = 32
) (
  input  logic          en,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  always_comb hit = en && (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/trc_evt_select.sv
module trc_evt_select
  import trc_pkg::*;
(
  input  logic              data_q,
  input  logic              br_q,
  input  logic              wp_q,
  input  logic [INFO_W-1:0] itype,
  input  logic [PC_W-1:0]   pc,
  input  logic [PC_W-1:0]   daddr,
  input  logic [PC_W-1:0]   ddata,
  input  logic [INFO_W-1:0] wp_id,
  output logic [1:0]        n,
  output body_t             m0,
  output body_t             m1
);
  always_comb begin
    n  = 2'd0;
    m0 = '0;
    m1 = '0;
    if (data_q) begin
      n          = 2'd2;
      m0.kind    = K_DADDR;
      m0.payload = daddr;
      m1.kind    = K_DVAL;
      m1.payload = ddata;
    end else if (br_q) begin
      n          = 2'd1;
      m0.kind    = K_BRANCH;
      m0.info    = itype;
      m0.payload = pc;
    end else if (wp_q) begin
      n          = 2'd1;
      m0.kind    = K_WATCH;
      m0.info    = wp_id;
    end
  end
endmodule

// File: rtl/trc_msg_fifo.sv
module trc_msg_fifo
  import trc_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    wr_n,
  input  msg_t          wd0,
  input  msg_t          wd1,
  input  logic          rd,
  output msg_t          rdata,
  output logic [CW-1:0] count
);
  msg_t          mem [DEPTH];
  logic [AW-1:0] wp;
  logic [AW-1:0] rp;

  always_ff @(posedge clk) begin
    if (wr_n != 2'd0) mem[wp] <= wd0;
    if (wr_n == 2'd2) mem[wp + AW'(1)] <= wd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      wp    <= wp + AW'(wr_n);
      rp    <= rp + AW'(rd);
      count <= count + CW'(wr_n) - CW'(rd);
    end
  end

  assign rdata = mem[rp];
endmodule

// File: rtl/trc_msg_encoder.sv
module trc_msg_encoder
  import trc_pkg::*;
#(
  parameter  int DEPTH    = 16,
  parameter  int NUM_RNG  = 4,
  parameter  int SYNC_LVL = 8,
  localparam int AW       = $clog2(DEPTH),
  localparam int CW       = AW + 1,
  localparam int CAP      = DEPTH - 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    retire_valid,
  input  logic                    retire_nonseq,
  input  logic [INFO_W-1:0]       retire_itype,
  input  logic [PC_W-1:0]         retire_pc,
  input  logic                    dacc_valid,
  input  logic                    dacc_core,
  input  logic [PC_W-1:0]         dacc_addr,
  input  logic [PC_W-1:0]         dacc_data,
  input  logic                    wp_hit,
  input  logic [INFO_W-1:0]       wp_id,
  input  logic                    trace_on,
  input  logic                    trace_off,
  input  logic                    record_all,
  input  logic [NUM_RNG-1:0]      rng_en,
  input  logic [NUM_RNG*PC_W-1:0] rng_lo,
  input  logic [NUM_RNG*PC_W-1:0] rng_hi,
  input  logic                    stall_en,
  output logic                    stall_req,
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [3:0]              out_kind,
  output logic [INFO_W-1:0]       out_info,
  output logic [PC_W-1:0]         out_payload,
  output logic [TS_W-1:0]         out_stamp
);
  logic [TS_W-1:0]    ts;
  logic               flow_en;
  logic [PC_W-1:0]    last_pc;
  logic               in_resync;
  logic [NUM_RNG-1:0] rng_hit;
  logic               data_q;
  logic               br_q;
  logic [1:0]         sel_n;
  body_t              sel_m0;
  body_t              sel_m1;
  logic [1:0]         wr_cnt;
  body_t              wb0;
  body_t              wb1;
  kind_e              wr_kind0;
  logic               go_ovf;
  logic               go_sync;
  logic [CW-1:0]      fifo_cnt;
  logic               rd;
  msg_t               rdata;

  // address qualifiers, one comparator per range
  for (genvar g = 0; g < NUM_RNG; g++) begin : g_rng
    trc_range_match #(.AW(PC_W)) u_match (
      .en   (rng_en[g]),
      .lo   (rng_lo[g*PC_W +: PC_W]),
      .hi   (rng_hi[g*PC_W +: PC_W]),
      .addr (dacc_addr),
      .hit  (rng_hit[g])
    );
  end

  assign data_q = dacc_valid && !dacc_core && (record_all || (|rng_hit));
  assign br_q   = retire_valid && retire_nonseq && flow_en;

  trc_evt_select u_sel (
    .data_q (data_q),
    .br_q   (br_q),
    .wp_q   (wp_hit),
    .itype  (retire_itype),
    .pc     (retire_pc),
    .daddr  (dacc_addr),
    .ddata  (dacc_data),
    .wp_id  (wp_id),
    .n      (sel_n),
    .m0     (sel_m0),
    .m1     (sel_m1)
  );

  // admission: normal space, overflow marker, resync
  always_comb begin
    wr_cnt  = 2'd0;
    wb0     = sel_m0;
    wb1     = sel_m1;
    go_ovf  = 1'b0;
    go_sync = 1'b0;
    if (!in_resync) begin
      if (sel_n != 2'd0) begin
        if (int'(fifo_cnt) + int'(sel_n) <= CAP) begin
          wr_cnt = sel_n;
        end else begin
          wr_cnt   = 2'd1;
          wb0      = '0;
          wb0.kind = K_OVF;
          go_ovf   = 1'b1;
        end
      end
    end else if (int'(fifo_cnt) <= SYNC_LVL) begin
      wr_cnt      = 2'd1;
      wb0         = '0;
      wb0.kind    = K_SYNC;
      wb0.payload = retire_valid ? retire_pc : last_pc;
      go_sync     = 1'b1;
    end
  end

  assign wr_kind0 = wb0.kind;

  always_ff @(posedge clk) begin
    if (rst) begin
      ts        <= '0;
      flow_en   <= 1'b1;
      last_pc   <= '0;
      in_resync <= 1'b0;
    end else begin
      ts <= ts + TS_W'(1);
      if (trace_off)     flow_en <= 1'b0;
      else if (trace_on) flow_en <= 1'b1;
      if (retire_valid)  last_pc <= retire_pc;
      if (go_ovf)        in_resync <= 1'b1;
      else if (go_sync)  in_resync <= 1'b0;
    end
  end

  assign rd = out_ready && (fifo_cnt != '0);

  trc_msg_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .wr_n  (wr_cnt),
    .wd0   ('{body: wb0, stamp: ts}),
    .wd1   ('{body: wb1, stamp: ts}),
    .rd    (rd),
    .rdata (rdata),
    .count (fifo_cnt)
  );

  assign out_valid   = (fifo_cnt != '0);
  assign out_kind    = rdata.body.kind;
  assign out_info    = rdata.body.info;
  assign out_payload = rdata.body.payload;
  assign out_stamp   = rdata.stamp;
  assign stall_req   = stall_en && (int'(fifo_cnt) >= CAP - 1);
endmodule

// File: rtl/trc_msg_encoder_chk.sv
module trc_msg_encoder_chk
  import trc_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          retire_valid,
  input logic          retire_nonseq,
  input logic          dacc_valid,
  input logic          dacc_core,
  input logic          wp_hit,
  input logic          stall_en,
  input logic          stall_req,
  input logic          out_ready,
  input logic          out_valid,
  input logic [3:0]    out_kind,
  input logic [PC_W-1:0] out_payload,
  input logic          in_resync,
  input logic [1:0]    wr_cnt,
  input logic [3:0]    wr_kind0,
  input logic [CW-1:0] fifo_cnt
);
  // R13
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_payload)));

  // R9
  stall_mode_chk: assert property (@(posedge clk) disable iff (rst)
    stall_req |-> stall_en);

  // R7
  no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    (int'(fifo_cnt) == DEPTH) |-> (wr_cnt == 2'd0));

  // R7
  ovf_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(in_resync) |-> ($past(wr_cnt) == 2'd1 && $past(wr_kind0) == K_OVF));

  // R8
  resync_only_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (in_resync && wr_cnt != 2'd0) |-> (wr_kind0 == K_SYNC && wr_cnt == 2'd1));

  // R2
  seq_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (retire_valid && !retire_nonseq && !dacc_valid && !wp_hit && !in_resync) |-> (wr_cnt == 2'd0));

  // R6
  core_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (dacc_valid && dacc_core && !retire_valid && !wp_hit && !in_resync) |-> (wr_cnt == 2'd0));
endmodule

bind trc_msg_encoder trc_msg_encoder_chk #(.DEPTH(DEPTH)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .retire_valid  (retire_valid),
  .retire_nonseq (retire_nonseq),
  .dacc_valid    (dacc_valid),
  .dacc_core     (dacc_core),
  .wp_hit        (wp_hit),
  .stall_en      (stall_en),
  .stall_req     (stall_req),
  .out_ready     (out_ready),
  .out_valid     (out_valid),
  .out_kind      (out_kind),
  .out_payload   (out_payload),
  .in_resync     (in_resync),
  .wr_cnt        (wr_cnt),
  .wr_kind0      (wr_kind0),
  .fifo_cnt      (fifo_cnt)
);

// File: tb/trc_msg_encoder_tb_top.sv
module trc_msg_encoder_tb_top;
  localparam int DEPTH = 16;
  localparam int SYNC_LVL = 8;

  typedef struct {
    logic [3:0]  k;
    logic [3:0]  i;
    logic [31:0] p;
    logic [15:0] s;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic retire_valid = 0, retire_nonseq = 0;
  logic [3:0] retire_itype = 0;
  logic [31:0] retire_pc = 0;
  logic dacc_valid = 0, dacc_core = 0;
  logic [31:0] dacc_addr = 0, dacc_data = 0;
  logic wp_hit = 0;
  logic [3:0] wp_id = 0;
  logic trace_on = 0, trace_off = 0, record_all = 0;
  logic [3:0] rng_en;
  logic [31:0] r_lo [4];
  logic [31:0] r_hi [4];
  logic [127:0] rng_lo, rng_hi;
  logic stall_en = 0;
  logic stall_req;
  logic out_ready = 0;
  logic out_valid;
  logic [3:0] out_kind, out_info;
  logic [31:0] out_payload;
  logic [15:0] out_stamp;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  exp_t mq[$];
  bit m_resync = 0;
  bit m_flow = 1;
  logic [31:0] m_last_pc = 0;
  logic [15:0] m_ts = 0;
  int m_ovf_cnt = 0;
  int m_sync_cnt = 0;

  always #10 clk = ~clk;

  assign rng_lo = {r_lo[3], r_lo[2], r_lo[1], r_lo[0]};
  assign rng_hi = {r_hi[3], r_hi[2], r_hi[1], r_hi[0]};

  trc_msg_encoder dut_i (
    .clk(clk), .rst(rst),
    .retire_valid(retire_valid), .retire_nonseq(retire_nonseq),
    .retire_itype(retire_itype), .retire_pc(retire_pc),
    .dacc_valid(dacc_valid), .dacc_core(dacc_core),
    .dacc_addr(dacc_addr), .dacc_data(dacc_data),
    .wp_hit(wp_hit), .wp_id(wp_id),
    .trace_on(trace_on), .trace_off(trace_off), .record_all(record_all),
    .rng_en(rng_en), .rng_lo(rng_lo), .rng_hi(rng_hi),
    .stall_en(stall_en), .stall_req(stall_req),
    .out_ready(out_ready), .out_valid(out_valid),
    .out_kind(out_kind), .out_info(out_info),
    .out_payload(out_payload), .out_stamp(out_stamp)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string kind_req(logic [3:0] k);
    case (k)
      4'h1: return "R1";
      4'h2, 4'h3: return "R4";
      4'h4: return "R7";
      4'h5: return "R8";
      4'h6: return "R11";
      default: return "R13";
    endcase
  endfunction

  function automatic bit qual(logic [31:0] a);
    for (int k = 0; k < 4; k++)
      if (rng_en[k] && a >= r_lo[k] && a <= r_hi[k]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic exp_t mk(logic [3:0] k, logic [3:0] i, logic [31:0] p);
    exp_t e;
    e.k = k; e.i = i; e.p = p; e.s = m_ts;
    return e;
  endfunction

  // one clock cycle: check outputs, advance the model, step the clock
  task automatic cyc(string tag);
    int cnt = mq.size();
    bit pop;
    bit dq, bq, wq;
    exp_t e0, e1;
    int n;
    check(tag, "out_valid", 32'(out_valid), 32'(cnt != 0));
    check("R9", "stall_req", 32'(stall_req), 32'(stall_en && cnt >= DEPTH - 3));
    pop = out_ready && (cnt != 0);
    if (pop) begin
      check(kind_req(mq[0].k), "kind", 32'(out_kind), 32'(mq[0].k));
      check(kind_req(mq[0].k), "info", 32'(out_info), 32'(mq[0].i));
      check(kind_req(mq[0].k), "payload", out_payload, mq[0].p);
      check("R3", "stamp", 32'(out_stamp), 32'(mq[0].s));
    end
    dq = dacc_valid && !dacc_core && (record_all || qual(dacc_addr));
    bq = retire_valid && retire_nonseq && m_flow;
    wq = wp_hit;
    n = 0;
    if (dq) begin
      n = 2; e0 = mk(4'h2, 4'h0, dacc_addr); e1 = mk(4'h3, 4'h0, dacc_data);
    end else if (bq) begin
      n = 1; e0 = mk(4'h1, retire_itype, retire_pc);
    end else if (wq) begin
      n = 1; e0 = mk(4'h6, wp_id, 32'h0);
    end
    if (!m_resync) begin
      if (n > 0) begin
        if (cnt + n <= DEPTH - 2) begin
          mq.push_back(e0);
          if (n == 2) mq.push_back(e1);
        end else begin
          mq.push_back(mk(4'h4, 4'h0, 32'h0));
          m_resync = 1;
          m_ovf_cnt++;
        end
      end
    end else if (cnt <= SYNC_LVL) begin
      mq.push_back(mk(4'h5, 4'h0, retire_valid ? retire_pc : m_last_pc));
      m_resync = 0;
      m_sync_cnt++;
    end
    if (pop) void'(mq.pop_front());
    if (retire_valid) m_last_pc = retire_pc;
    if (trace_off) m_flow = 0;
    else if (trace_on) m_flow = 1;
    m_ts = m_ts + 16'd1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    retire_valid = 0; retire_nonseq = 0; dacc_valid = 0; dacc_core = 0;
    wp_hit = 0; trace_on = 0; trace_off = 0;
  endtask

  task automatic rand_inputs(bit hold);
    int sel;
    idle_inputs();
    if (hold) return;
    sel = int'($urandom % 7);
    retire_itype = 4'($urandom);
    retire_pc = $urandom;
    dacc_data = $urandom;
    wp_id = 4'($urandom);
    case ($urandom % 4)
      0: dacc_addr = 32'h1000 + ($urandom % 256);
      1: dacc_addr = 32'h2000 + ($urandom % 6);
      2: dacc_addr = 32'h3000 + ($urandom % 16);
      default: dacc_addr = $urandom;
    endcase
    case (sel)
      0: retire_valid = 1;
      1: begin retire_valid = 1; retire_nonseq = 1; end
      2: dacc_valid = 1;
      3: begin dacc_valid = 1; dacc_core = 1; end
      4: wp_hit = 1;
      5: begin retire_valid = 1; retire_nonseq = 1; dacc_valid = 1; wp_hit = ($urandom % 2) == 1; end
      default: ;
    endcase
    if ($urandom % 50 == 0) trace_off = 1;
    if ($urandom % 40 == 0) trace_on = 1;
    if ($urandom % 300 == 0) record_all = ~record_all;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL R13 watchdog: actual=timeout expected=completion");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int ovf_before;
    void'($urandom(32'h5eed_7a11));
    rng_en = 4'b1011;
    r_lo[0] = 32'h1000; r_hi[0] = 32'h10FF;
    r_lo[1] = 32'h2000; r_hi[1] = 32'h2003;
    r_lo[2] = 32'h3000; r_hi[2] = 32'h3FFF;
    r_lo[3] = 32'hFFFF_FF00; r_hi[3] = 32'hFFFF_FFFF;
    stall_en = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    check("R12", "out_valid in reset", 32'(out_valid), 32'h0);
    check("R12", "stall_req in reset", 32'(stall_req), 32'h0);
    stall_en = 0;
    rst = 0;
    out_ready = 1;

    // R1 branch
    retire_valid = 1; retire_nonseq = 1; retire_itype = 4'h5; retire_pc = 32'h8000_0040;
    cyc("R1");
    idle_inputs(); cyc("R1"); cyc("R1");
    // R2 sequential
    retire_valid = 1; retire_pc = 32'h8000_0044;
    cyc("R2");
    idle_inputs(); cyc("R2"); cyc("R2");
    // R4/R5 data in range, boundary addresses
    dacc_valid = 1; dacc_addr = 32'h10FF; dacc_data = 32'hCAFE_0001; cyc("R4");
    dacc_addr = 32'h2003; dacc_data = 32'hCAFE_0002; cyc("R5");
    dacc_addr = 32'hFFFF_FF00; dacc_data = 32'hCAFE_0003; cyc("R5");
    // R5 outside and disabled range
    dacc_addr = 32'h1100; cyc("R5");
    dacc_addr = 32'h3004; cyc("R5");
    idle_inputs(); cyc("R5"); cyc("R5"); cyc("R5");
    check("R5", "queue after unqualified", 32'(out_valid), 32'h0);
    record_all = 1; dacc_valid = 1; dacc_addr = 32'h3004; dacc_data = 32'h0BAD_F00D; cyc("R5");
    // R6 core access ignored even with record_all
    dacc_core = 1; dacc_addr = 32'h1010; cyc("R6");
    idle_inputs(); cyc("R6"); cyc("R6");
    check("R6", "queue after core access", 32'(out_valid), 32'h0);
    record_all = 0;
    // R10 trace gating
    trace_off = 1; cyc("R10");
    idle_inputs(); retire_valid = 1; retire_nonseq = 1; retire_pc = 32'h8000_1000; cyc("R10");
    trace_on = 1; retire_pc = 32'h8000_1004; cyc("R10");
    trace_on = 0; retire_pc = 32'h8000_1008; cyc("R10");
    trace_on = 1; trace_off = 1; retire_pc = 32'h8000_100C; cyc("R10");
    trace_on = 0; trace_off = 0; retire_pc = 32'h8000_1010; cyc("R10");
    trace_on = 1; idle_inputs(); trace_on = 1; cyc("R10");
    idle_inputs(); cyc("R10"); cyc("R10");
    // R11 priority
    retire_valid = 1; retire_nonseq = 1; retire_pc = 32'h8000_2000; retire_itype = 4'h2;
    dacc_valid = 1; dacc_addr = 32'h1001; dacc_data = 32'h1111_2222; wp_hit = 1; wp_id = 4'h9;
    cyc("R11");
    dacc_valid = 0; cyc("R11");
    retire_valid = 0; cyc("R11");
    idle_inputs(); cyc("R11"); cyc("R11"); cyc("R11");

    // R7/R8 overflow and resync
    out_ready = 0;
    for (int k = 0; k < 16; k++) begin
      retire_valid = 1; retire_nonseq = 1; retire_itype = 4'(k); retire_pc = 32'h9000_0000 + 32'(k*4);
      cyc("R7");
    end
    idle_inputs();
    dacc_valid = 1; dacc_addr = 32'h1004; cyc("R8");
    idle_inputs();
    check("R7", "overflow count", 32'(m_ovf_cnt), 32'h1);
    out_ready = 1;
    for (int k = 0; k < 20; k++) begin
      retire_valid = 1; retire_nonseq = (k % 3) == 0; retire_pc = 32'hA000_0000 + 32'(k*4);
      cyc("R8");
    end
    idle_inputs();
    check("R8", "sync count", 32'(m_sync_cnt), 32'h1);
    repeat (4) cyc("R13");

    // R9 directed stall
    stall_en = 1; out_ready = 0;
    for (int k = 0; k < 8; k++) begin
      rand_inputs(mq.size() >= DEPTH - 3);
      dacc_valid = (mq.size() < DEPTH - 3); dacc_core = 0; dacc_addr = 32'h1020;
      retire_valid = 0; wp_hit = 0;
      cyc("R9");
    end
    idle_inputs();
    check("R9", "stall_req at high occupancy", 32'(stall_req), 32'h1);
    out_ready = 1;
    repeat (16) cyc("R9");
    stall_en = 0;

    // random: dropping mode
    for (int k = 0; k < 2500; k++) begin
      rand_inputs(1'b0);
      out_ready = ($urandom % 100) < 45;
      cyc("R13");
    end
    // random: stall mode, core obeys stall
    idle_inputs();
    repeat (20) begin out_ready = 1; cyc("R13"); end
    stall_en = 1;
    ovf_before = m_ovf_cnt;
    for (int k = 0; k < 2500; k++) begin
      rand_inputs(mq.size() >= DEPTH - 3);
      out_ready = ($urandom % 100) < 30;
      cyc("R9");
    end
    check("R9", "overflows in stall mode", 32'(m_ovf_cnt - ovf_before), 32'h0);
    stall_en = 0;
    // random: mostly draining
    for (int k = 0; k < 1500; k++) begin
      rand_inputs(1'b0);
      out_ready = ($urandom % 100) < 80;
      cyc("R13");
    end
    idle_inputs(); out_ready = 1;
    repeat (40) cyc("R13");
    check("R13", "drained", 32'(out_valid), 32'h0);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule